// File: doc/BRIEF.md
# Add/Subtract Unit with Carry and Zero Flags

This block is the arithmetic stage of a small accumulator datapath. It takes two register operands and forms either their sum or their difference with no clock involved: the result follows the operands and the subtract control as soon as they change. Subtraction is done by inverting the second operand bit by bit and feeding the subtract control into the carry input. Together these give the two's complement of the second operand.

The result reaches the shared datapath bus only while the bus enable is asserted. At all other times the bus output floats. A two-bit flags register holds the adder's carry-out and a zero indication. Those two bits feed conditional branch decisions elsewhere. The register captures new flag values only on a clock edge where the flag-load strobe is high. Between loads it holds its contents, whatever the operands do.

Top module: `addsub_flags_unit`

## Requirements
- R1: With subtract low, the result equals (A + B) modulo 2^WIDTH and follows the operands combinationally, with no clock edge needed.
- R2: With subtract high, the result equals (A + ~B + 1) modulo 2^WIDTH, which is A − B in two's complement.
- R3: The carry flag is the adder's carry-out from the top bit. For addition it is 1 exactly when A + B ≥ 2^WIDTH. For subtraction it is 1 exactly when A ≥ B unsigned, meaning no borrow occurred.
- R4: The zero flag is 1 exactly when every bit of the result is 0.
- R5: The flags register loads carry and zero on a rising clock edge only when the load strobe is high. On any edge with the strobe low it keeps its previous value, even if the operands or subtract control change.
- R6: The bus output carries the result while the bus enable is high and is high-impedance while it is low.
- R7: A synchronous active-high reset clears both flags to 0 and takes priority over a simultaneous load.
- R8: The carry_o and zero_o outputs present the stored flag values and not the live adder values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (inverted when subtracting) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| bus_oe_i | input | 1 | Drive the result onto the bus |
| flag_ld_i | input | 1 | Capture carry and zero on the next rising edge |
| bus_o | output | WIDTH | Result, high-impedance when not enabled |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | Stored zero flag |

## Verification
The bench builds two copies of the unit. One uses the default WIDTH of 8 and runs a vector table plus directed reset, hold and bus-release tests. The other uses WIDTH of 4, which makes every combination of operands and operation reachable in a few hundred cycles. Every carry, borrow and zero boundary is therefore checked exhaustively on the narrow copy. The wide copy covers the wrap cases at 0x00, 0x7F, 0x80 and 0xFF.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Stored and computed condition bits
    typedef struct packed {
        logic carry;
        logic zero;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_CLEAR = '{carry: 1'b0, zero: 1'b0};

endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              sub_i,
    output logic [WIDTH-1:0]  sum_o,
    output alu_pkg::alu_flags_t flags_o
);
    localparam int WIDE = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDE-1:0]  wide_sum;

    // Per-bit conditional inversion of B
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_inv
            assign b_eff[i] = b_i[i] ^ sub_i;
        end
    endgenerate

    assign wide_sum      = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    assign sum_o         = wide_sum[WIDTH-1:0];
    assign flags_o.carry = wide_sum[WIDTH];
    assign flags_o.zero  = ~|wide_sum[WIDTH-1:0];

    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            if (sub_i) begin
                assert_sub_result_R2: assert (sum_o == a_i - b_i);
                assert_no_borrow_R3:  assert (flags_o.carry == (a_i >= b_i));
            end else begin
                assert_add_result_R1: assert (sum_o == a_i + b_i);
                assert_add_carry_R3:  assert (flags_o.carry == (a_i > ~b_i));
            end
        end
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_i,
    input  alu_pkg::alu_flags_t d_i,
    output alu_pkg::alu_flags_t q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= alu_pkg::FLAGS_CLEAR;
        else if (ld_i) q_o <= d_i;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> $stable(q_o));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> q_o == $past(d_i));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> q_o == alu_pkg::FLAGS_CLEAR);

endmodule

// File: rtl/alu_bus_drv.sv
module alu_bus_drv #(
    parameter int WIDTH = 8
) (
    input  logic             oe_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] bus_o
);
    assign bus_o = oe_i ? data_i : 'z;

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic             bus_oe_i,
    input  logic             flag_ld_i,
    output logic [WIDTH-1:0] bus_o,
    output logic             carry_o,
    output logic             zero_o
);
    logic [WIDTH-1:0]    sum;
    alu_pkg::alu_flags_t live_flags;
    alu_pkg::alu_flags_t held_flags;

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (sub_i),
        .sum_o   (sum),
        .flags_o (live_flags)
    );

    alu_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .ld_i (flag_ld_i),
        .d_i  (live_flags),
        .q_o  (held_flags)
    );

    alu_bus_drv #(.WIDTH(WIDTH)) u_bus (
        .oe_i   (bus_oe_i),
        .data_i (sum),
        .bus_o  (bus_o)
    );

    assign carry_o = held_flags.carry;
    assign zero_o  = held_flags.zero;

    // R8: stored zero reflects the result seen at the loading edge
    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        flag_ld_i |=> zero_o == ($past(sum) == '0));

endmodule

// File: tb/addsub_flags_unit_tb.sv
module addsub_flags_unit_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    // 8-bit instance
    logic       rst, sub, oe, ld;
    logic [7:0] a, b, bus;
    logic       carry, zero;

    addsub_flags_unit #(.WIDTH(8)) u_dut (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sub_i(sub),
        .bus_oe_i(oe), .flag_ld_i(ld), .bus_o(bus),
        .carry_o(carry), .zero_o(zero)
    );

    // 4-bit instance for exhaustive sweep
    logic       sub4;
    logic [3:0] a4, b4, bus4;
    logic       carry4, zero4;

    addsub_flags_unit #(.WIDTH(4)) u_dut4 (
        .clk(clk), .rst(rst), .a_i(a4), .b_i(b4), .sub_i(sub4),
        .bus_oe_i(1'b1), .flag_ld_i(1'b1), .bus_o(bus4),
        .carry_o(carry4), .zero_o(zero4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic       sub;
        logic [7:0] res;
        logic       c;
        logic       z;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 8'h03, 1'b0, 8'h08, 1'b0, 1'b0},
        '{8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1},
        '{8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1},
        '{8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b0},
        '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1},
        '{8'h05, 8'h03, 1'b1, 8'h02, 1'b1, 1'b0},
        '{8'h03, 8'h05, 1'b1, 8'hFE, 1'b0, 1'b0},
        '{8'h42, 8'h42, 1'b1, 8'h00, 1'b1, 1'b1},
        '{8'h00, 8'h01, 1'b1, 8'hFF, 1'b0, 1'b0},
        '{8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1}
    };

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a = '0; b = '0; sub = 1'b0; oe = 1'b0; ld = 1'b0;
        a4 = '0; b4 = '0; sub4 = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset carry", {31'd0, carry}, 32'd0);
        check("R7 reset zero",  {31'd0, zero},  32'd0);
        rst = 1'b0;

        // Vector table: R1 R2 on bus, R3 R4 after load
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a = VECS[i].a; b = VECS[i].b; sub = VECS[i].sub; oe = 1'b1; ld = 1'b1;
            #1;
            check(VECS[i].sub ? "R2 result" : "R1 result", {24'd0, bus}, {24'd0, VECS[i].res});
            @(negedge clk);
            ld = 1'b0;
            check("R3 carry", {31'd0, carry}, {31'd0, VECS[i].c});
            check("R4 zero",  {31'd0, zero},  {31'd0, VECS[i].z});
        end

        // R1: result follows operands with no clock edge
        @(negedge clk);
        a = 8'h10; b = 8'h20; sub = 1'b0; #1;
        check("R1 combinational", {24'd0, bus}, 32'h30);
        a = 8'h11; #1;
        check("R1 combinational", {24'd0, bus}, 32'h31);

        // R5/R8: load 0x00-0x01 (c=0,z=0), then hold while operands change
        @(negedge clk);
        a = 8'h00; b = 8'h01; sub = 1'b1; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        a = 8'h33; b = 8'h33; sub = 1'b1;   // live flags c=1 z=1
        repeat (3) @(negedge clk);
        check("R5 hold carry", {31'd0, carry}, 32'd0);
        check("R8 stored zero", {31'd0, zero}, 32'd0);
        ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        check("R5 load carry", {31'd0, carry}, 32'd1);
        check("R5 load zero",  {31'd0, zero},  32'd1);

        // R6: bus released when enable low
        oe = 1'b0; a = 8'hA5; b = 8'h00; sub = 1'b0; #1;
        checks++;
        if (!((bus === 8'hzz) || (bus === 8'h00))) begin
            failures++;
            $display("FAIL R6 bus not released actual=%0h expected=zz", bus);
        end
        oe = 1'b1; #1;
        check("R6 bus driven", {24'd0, bus}, 32'hA5);

        // R7: reset beats a simultaneous load of c=1 z=1
        @(negedge clk);
        a = 8'h07; b = 8'h07; sub = 1'b1; ld = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R7 reset over load carry", {31'd0, carry}, 32'd0);
        check("R7 reset over load zero",  {31'd0, zero},  32'd0);
        rst = 1'b0; ld = 1'b0;

        // Exhaustive 4-bit sweep: R1 R2 R3 R4
        for (int op = 0; op < 2; op++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    int r;
                    int c;
                    @(negedge clk);
                    a4 = 4'(x); b4 = 4'(y); sub4 = op[0];
                    r = op ? ((x - y) & 15) : ((x + y) & 15);
                    c = op ? int'(x >= y) : int'(x + y > 15);
                    #1;
                    check(op ? "R2 sweep" : "R1 sweep", {28'd0, bus4}, r);
                    @(negedge clk);
                    check("R3 sweep carry", {31'd0, carry4}, c);
                    check("R4 sweep zero",  {31'd0, zero4},  int'(r == 0));
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule